// File: doc/BRIEF.md
# I2C Master Stop-Condition Sequencer

This block ends a transaction on an I2C bus from the master side. A byte transfer finishes with SCL parked low after the last falling clock edge. Firmware can then set a stop-enable bit. The block then walks the bus through the STOP pattern. It pulls SDA low, lets SCL rise, and then lets SDA rise. Every step is paced by a reloadable baud down-counter. Every step also waits until the level it asked for is read back from the pins. Because of this, a slave that stretches SCL delays the sequence and does not corrupt it.

When the pins show SDA rising while SCL is high, a stop-detected flag goes up. One baud period later the enable bit clears itself and an interrupt flag is raised. A buffer write that arrives while the sequence runs is refused and raises a write-collision flag. A small bus monitor watches both pins at all times. It keeps a start-seen flag and a stop-seen flag, so firmware can tell whether the bus is free.

The pins are open-drain. An `_oe` output of 1 pulls the line low. The `_i` inputs are the actual line levels, passed through `SYNC_STAGES` synchronizer flops (default 2). In what follows, S is `SYNC_STAGES` and P is the baud reload value plus one, in clocks.

Top module: `i2c_stop_gen`

## Requirements
- R1: While reset is held, scl_oe_o, sda_oe_o, stop_en_o, irq_o, wcol_o, start_seen_o and stop_seen_o are 0, and buf_o is 0.
- R2: A pulse on xfer_done_i parks the block, and scl_oe_o goes to 1. While parked and idle, a stop_wr_i strobe with stop_wdata_i=1 sets stop_en_o and sda_oe_o to 1 from the following cycle.
- R3: Once SDA reads low, the counter runs one period P, and then scl_oe_o drops. The rising edge of sda_oe_o and the falling edge of scl_oe_o are P+S+1 cycles apart.
- R4: While SCL still reads low after release (a slave stretching the clock), the counter does not start. Each extra cycle of SCL held low adds one cycle to the delay before SDA is released.
- R5: With no stretching, sda_oe_o falls P+S+1 cycles after scl_oe_o falls, and scl_oe_o is 0 when it does.
- R6: stop_seen_o rises S+1 cycles after sda_oe_o falls. P+S+1 cycles after that fall, stop_en_o clears and irq_o rises in the same cycle. irq_o stays set until an irq_clr_i strobe.
- R7: A buf_wr_i strobe while stop_en_o is 1 sets wcol_o and leaves buf_o unchanged. When idle, the strobe loads buf_wdata_i into buf_o. wcol_o stays set until wcol_clr_i.
- R8: start_seen_o is set by SDA falling while SCL is high, and cleared when a stop is seen. stop_seen_o is set by SDA rising while SCL is high, and cleared when a start is seen. The two flags are never 1 together.
- R9: A stop_wdata_i=1 request while not parked is ignored, and stop_en_o and sda_oe_o stay 0. A stop_wdata_i=0 write during a sequence leaves stop_en_o at 1 and the timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brg_reload_i | input | BRG_W | Baud counter reload value (period = value+1 clocks) |
| xfer_done_i | input | 1 | Pulse: byte transfer finished, SCL parked low |
| stop_wr_i | input | 1 | Write strobe for the stop-enable bit |
| stop_wdata_i | input | 1 | Value written to the stop-enable bit |
| buf_wr_i | input | 1 | Transmit buffer write strobe |
| buf_wdata_i | input | DATA_W | Transmit buffer write data |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| wcol_clr_i | input | 1 | Clears the write-collision flag |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| stop_en_o | output | 1 | Stop-enable bit, cleared by hardware |
| start_seen_o | output | 1 | Bus monitor: START seen (bus busy) |
| stop_seen_o | output | 1 | Bus monitor: STOP seen (bus free) |
| irq_o | output | 1 | Interrupt flag |
| wcol_o | output | 1 | Write-collision flag |
| buf_o | output | DATA_W | Transmit buffer contents |

## Verification
The assertions assume open-drain pins that no other device drives against the block during a sequence. They also assume that no START shows up between SDA release and the end of the sequence, since the tail checks expect stop-seen still high when the enable clears. The bench models each line as the AND of the block's release and an external pull-down. It only stretches SCL, and only after the block has released it. It only makes START and idle-time bus activity before a transfer is parked. This keeps the stimulus inside those assumptions.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SDA_LO  = 3'd1,
      ST_HOLD_LO = 3'd2,
      ST_SCL_REL = 3'd3,
      ST_HOLD_HI = 3'd4,
      ST_SDA_REL = 3'd5,
      ST_TAIL    = 3'd6
   } stop_state_e;

   localparam int MAX_SYNC_STAGES = 4;

endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic pin_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign pin_o = pin_i;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[0] <= 1'b1;
            else        sh_q[0] <= pin_i;
         end
         for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh_q[i] <= 1'b1;
               else        sh_q[i] <= sh_q[i-1];
            end
         end
         assign pin_o = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/i2c_baud_timer.sv
module i2c_baud_timer #(
   parameter int BRG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [BRG_W-1:0] reload_i,
   output logic             expired_o
);

   localparam logic [BRG_W-1:0] CNT_ZERO = '0;
   localparam logic [BRG_W-1:0] CNT_ONE  = {{(BRG_W-1){1'b0}}, 1'b1};

   logic [BRG_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= CNT_ZERO;
      else if (load_i)           cnt_q <= reload_i;
      else if (cnt_q != CNT_ZERO) cnt_q <= cnt_q - CNT_ONE;
   end

   assign expired_o = (cnt_q == CNT_ZERO);

endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic start_o,
   output logic stop_o
);

   logic sda_d_q;
   logic start_ev;
   logic stop_ev;
   logic start_q;
   logic stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sda_d_q <= 1'b1;
      else        sda_d_q <= sda_s_i;
   end

   assign start_ev = scl_s_i &  sda_d_q & ~sda_s_i;
   assign stop_ev  = scl_s_i & ~sda_d_q &  sda_s_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         stop_q  <= 1'b0;
      end else if (start_ev) begin
         start_q <= 1'b1;
         stop_q  <= 1'b0;
      end else if (stop_ev) begin
         start_q <= 1'b0;
         stop_q  <= 1'b1;
      end
   end

   assign start_o = start_q;
   assign stop_o  = stop_q;

endmodule

// File: rtl/i2c_stop_fsm.sv
module i2c_stop_fsm
   import i2c_stop_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   input  logic expired_i,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic busy_o,
   output logic sda_drive_o,
   output logic scl_drive_o,
   output logic load_o,
   output logic done_o
);

   stop_state_e state_q;
   stop_state_e state_d;

   always_comb begin
      state_d = state_q;
      load_o  = 1'b0;
      done_o  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (go_i) state_d = ST_SDA_LO;
         end
         ST_SDA_LO: begin
            if (!sda_s_i) begin
               load_o  = 1'b1;
               state_d = ST_HOLD_LO;
            end
         end
         ST_HOLD_LO: begin
            if (expired_i) state_d = ST_SCL_REL;
         end
         ST_SCL_REL: begin
            if (scl_s_i) begin
               load_o  = 1'b1;
               state_d = ST_HOLD_HI;
            end
         end
         ST_HOLD_HI: begin
            if (expired_i) state_d = ST_SDA_REL;
         end
         ST_SDA_REL: begin
            if (sda_s_i && scl_s_i) begin
               load_o  = 1'b1;
               state_d = ST_TAIL;
            end
         end
         ST_TAIL: begin
            if (expired_i) begin
               done_o  = 1'b1;
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign sda_drive_o = (state_q == ST_SDA_LO) || (state_q == ST_HOLD_LO) ||
                        (state_q == ST_SCL_REL) || (state_q == ST_HOLD_HI);
   assign scl_drive_o = (state_q == ST_SDA_LO) || (state_q == ST_HOLD_LO);

endmodule

// File: rtl/i2c_stop_gen.sv
module i2c_stop_gen
   import i2c_stop_pkg::*;
#(
   parameter int BRG_W       = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BRG_W-1:0]  brg_reload_i,
   input  logic              xfer_done_i,
   input  logic              stop_wr_i,
   input  logic              stop_wdata_i,
   input  logic              buf_wr_i,
   input  logic [DATA_W-1:0] buf_wdata_i,
   input  logic              irq_clr_i,
   input  logic              wcol_clr_i,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe_o,
   output logic              sda_oe_o,
   output logic              stop_en_o,
   output logic              start_seen_o,
   output logic              stop_seen_o,
   output logic              irq_o,
   output logic              wcol_o,
   output logic [DATA_W-1:0] buf_o
);

   generate
      if (BRG_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("i2c_stop_gen: BRG_W and DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > MAX_SYNC_STAGES) begin : g_bad_sync
         $error("i2c_stop_gen: SYNC_STAGES out of range");
      end
   endgenerate

   logic scl_s;
   logic sda_s;
   logic busy;
   logic sda_drive;
   logic scl_drive;
   logic tmr_load;
   logic tmr_expired;
   logic seq_done;
   logic go;
   logic parked_q;
   logic stop_en_q;
   logic irq_q;
   logic wcol_q;
   logic [DATA_W-1:0] buf_q;

   i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (scl_i),
      .pin_o (scl_s)
   );

   i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (sda_i),
      .pin_o (sda_s)
   );

   i2c_baud_timer #(.BRG_W(BRG_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tmr_load),
      .reload_i  (brg_reload_i),
      .expired_o (tmr_expired)
   );

   i2c_stop_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_i        (go),
      .expired_i   (tmr_expired),
      .scl_s_i     (scl_s),
      .sda_s_i     (sda_s),
      .busy_o      (busy),
      .sda_drive_o (sda_drive),
      .scl_drive_o (scl_drive),
      .load_o      (tmr_load),
      .done_o      (seq_done)
   );

   i2c_bus_watch u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_s_i (scl_s),
      .sda_s_i (sda_s),
      .start_o (start_seen_o),
      .stop_o  (stop_seen_o)
   );

   // A stop request is only taken while a finished transfer holds SCL.
   assign go = stop_wr_i & stop_wdata_i & parked_q & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           parked_q <= 1'b0;
      else if (go)          parked_q <= 1'b0;
      else if (xfer_done_i) parked_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stop_en_q <= 1'b0;
      else if (go)       stop_en_q <= 1'b1;
      else if (seq_done) stop_en_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_q <= 1'b0;
      else if (seq_done)  irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wcol_q <= 1'b0;
      else if (buf_wr_i && busy) wcol_q <= 1'b1;
      else if (wcol_clr_i)       wcol_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 buf_q <= '0;
      else if (buf_wr_i && !busy) buf_q <= buf_wdata_i;
   end

   assign scl_oe_o  = parked_q | scl_drive;
   assign sda_oe_o  = sda_drive;
   assign stop_en_o = stop_en_q;
   assign irq_o     = irq_q;
   assign wcol_o    = wcol_q;
   assign buf_o     = buf_q;

endmodule

// File: rtl/i2c_stop_gen_chk.sv
module i2c_stop_gen_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_oe_o,
   input logic              sda_oe_o,
   input logic              stop_en_o,
   input logic              start_seen_o,
   input logic              stop_seen_o,
   input logic              irq_o,
   input logic              wcol_o,
   input logic              buf_wr_i,
   input logic [DATA_W-1:0] buf_o
);

   AST_SDA_OE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe_o |-> stop_en_o); // R2

   AST_SCL_REL_SDA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_oe_o) && stop_en_o) |-> sda_oe_o); // R3

   AST_SDA_REL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sda_oe_o) && stop_en_o) |-> !scl_oe_o); // R5

   AST_CLEAR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_en_o) |-> irq_o); // R6

   AST_CLEAR_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_en_o) |-> stop_seen_o); // R6

   AST_WCOL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_wr_i && stop_en_o) |=> (wcol_o && $stable(buf_o))); // R7

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_seen_o && stop_seen_o)); // R8

endmodule

bind i2c_stop_gen i2c_stop_gen_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .scl_oe_o     (scl_oe_o),
   .sda_oe_o     (sda_oe_o),
   .stop_en_o    (stop_en_o),
   .start_seen_o (start_seen_o),
   .stop_seen_o  (stop_seen_o),
   .irq_o        (irq_o),
   .wcol_o       (wcol_o),
   .buf_wr_i     (buf_wr_i),
   .buf_o        (buf_o)
);

// File: tb/i2c_stop_gen_bench.sv
module i2c_stop_gen_bench;

   localparam int BRG_W  = 8;
   localparam int DATA_W = 8;
   localparam int SYNC   = 2;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n;
   logic [BRG_W-1:0]  brg_reload;
   logic              xfer_done, stop_wr, stop_wdata, buf_wr, irq_clr, wcol_clr;
   logic [DATA_W-1:0] buf_wdata;
   logic              scl_line, sda_line;
   logic              scl_oe, sda_oe, stop_en, start_seen, stop_seen, irq, wcol;
   logic [DATA_W-1:0] buf_q;
   logic              ext_scl_low, ext_sda_low;

   assign scl_line = ~(scl_oe | ext_scl_low);
   assign sda_line = ~(sda_oe | ext_sda_low);

   i2c_stop_gen #(.BRG_W(BRG_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC)) u_i2c_stop_gen (
      .clk (clk), .rst_n (rst_n), .brg_reload_i (brg_reload),
      .xfer_done_i (xfer_done), .stop_wr_i (stop_wr), .stop_wdata_i (stop_wdata),
      .buf_wr_i (buf_wr), .buf_wdata_i (buf_wdata), .irq_clr_i (irq_clr),
      .wcol_clr_i (wcol_clr), .scl_i (scl_line), .sda_i (sda_line),
      .scl_oe_o (scl_oe), .sda_oe_o (sda_oe), .stop_en_o (stop_en),
      .start_seen_o (start_seen), .stop_seen_o (stop_seen), .irq_o (irq),
      .wcol_o (wcol), .buf_o (buf_q)
   );

   int n_run  = 0;
   int n_fail = 0;

   task automatic check(input string req, input string what, input int act, input int expv);
      n_run++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   typedef struct {
      int g_scl;
      int g_sda;
      int g_irq;
      int g_stop;
   } exp_t;

   exp_t exp_q[$];

   // Monitor: time stamps of pin and flag edges, compared at each interrupt.
   int cyc = 0;
   int t_sda_lo, t_scl_rel, t_sda_rel, t_stop;
   logic p_sda_oe = 1'b0, p_scl_oe = 1'b0, p_irq = 1'b0, p_stop = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (sda_oe && !p_sda_oe)             t_sda_lo  = cyc;
         if (!scl_oe && p_scl_oe && stop_en)  t_scl_rel = cyc;
         if (!sda_oe && p_sda_oe)             t_sda_rel = cyc;
         if (stop_seen && !p_stop)            t_stop    = cyc;
         if (irq && !p_irq) begin
            if (exp_q.size() == 0) begin
               check("R6", "unexpected interrupt", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check("R3", "SDA low to SCL release gap", t_scl_rel - t_sda_lo, e.g_scl);
               check("R5", "SCL release to SDA release gap (R4 when stretched)",
                     t_sda_rel - t_scl_rel, e.g_sda);
               check("R6", "SDA release to stop-detected gap", t_stop - t_sda_rel, e.g_stop);
               check("R6", "SDA release to interrupt gap", cyc - t_sda_rel, e.g_irq);
               check("R6", "stop enable cleared with interrupt", int'(stop_en), 0);
            end
         end
      end
      p_sda_oe = sda_oe;
      p_scl_oe = scl_oe;
      p_irq    = irq;
      p_stop   = stop_seen;
   end

   task automatic bus_start();
      @(negedge clk);
      ext_sda_low = 1'b1;
      repeat (SYNC + 3) @(negedge clk);
      check("R8", "start flag after SDA fall with SCL high", int'(start_seen), 1);
      check("R8", "stop flag cleared by start", int'(stop_seen), 0);
      ext_scl_low = 1'b1;
      repeat (3) @(negedge clk);
      ext_sda_low = 1'b0;
      repeat (SYNC + 3) @(negedge clk);
      check("R8", "SDA rise with SCL low is not a stop", int'(stop_seen), 0);
   endtask

   task automatic run_seq(input int reload, input int k, input bit extras);
      exp_t e;
      bus_start();
      brg_reload = BRG_W'(reload);
      xfer_done  = 1'b1;
      @(negedge clk);
      xfer_done  = 1'b0;
      @(negedge clk);
      check("R2", "SCL parked after transfer", int'(scl_oe), 1);
      if (k == 0) ext_scl_low = 1'b0;
      e.g_scl  = reload + SYNC + 2;
      e.g_sda  = reload + SYNC + 2 + k;
      e.g_irq  = reload + SYNC + 2;
      e.g_stop = SYNC + 1;
      exp_q.push_back(e);
      stop_wr    = 1'b1;
      stop_wdata = 1'b1;
      @(negedge clk);
      stop_wr    = 1'b0;
      check("R2", "stop enable set", int'(stop_en), 1);
      check("R2", "SDA pulled low", int'(sda_oe), 1);
      fork
         begin
            if (k > 0) begin
               while (scl_oe) @(negedge clk);
               repeat (k) @(posedge clk);
               @(negedge clk);
               ext_scl_low = 1'b0;
            end
         end
         begin
            if (extras) begin
               stop_wr    = 1'b1;
               stop_wdata = 1'b0;
               @(negedge clk);
               stop_wr    = 1'b0;
               check("R9", "zero write keeps stop enable", int'(stop_en), 1);
               buf_wr    = 1'b1;
               buf_wdata = 8'hA5;
               @(negedge clk);
               buf_wr    = 1'b0;
               check("R7", "collision flag on busy write", int'(wcol), 1);
               check("R7", "buffer unchanged on busy write", int'(buf_q), 8'h3C);
            end
         end
      join
      while (!irq) @(negedge clk);
      check("R8", "stop flag after sequence", int'(stop_seen), 1);
      check("R8", "start flag cleared by stop", int'(start_seen), 0);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check("R6", "interrupt cleared by strobe", int'(irq), 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic run_all();
      rst_n = 1'b0;
      brg_reload = '0; xfer_done = 1'b0; stop_wr = 1'b0; stop_wdata = 1'b0;
      buf_wr = 1'b0; buf_wdata = '0; irq_clr = 1'b0; wcol_clr = 1'b0;
      ext_scl_low = 1'b0; ext_sda_low = 1'b0;
      repeat (4) @(negedge clk);
      check("R1", "scl_oe in reset", int'(scl_oe), 0);
      check("R1", "sda_oe in reset", int'(sda_oe), 0);
      check("R1", "stop_en in reset", int'(stop_en), 0);
      check("R1", "irq in reset", int'(irq), 0);
      check("R1", "wcol in reset", int'(wcol), 0);
      check("R1", "start flag in reset", int'(start_seen), 0);
      check("R1", "stop flag in reset", int'(stop_seen), 0);
      check("R1", "buffer in reset", int'(buf_q), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R9: request with no finished transfer
      stop_wr = 1'b1; stop_wdata = 1'b1;
      @(negedge clk);
      stop_wr = 1'b0;
      check("R9", "unparked request ignored (enable)", int'(stop_en), 0);
      repeat (4) @(negedge clk);
      check("R9", "unparked request ignored (SDA)", int'(sda_oe), 0);

      // R7: idle write lands in the buffer
      buf_wr = 1'b1; buf_wdata = 8'h3C;
      @(negedge clk);
      buf_wr = 1'b0;
      check("R7", "idle write loads buffer", int'(buf_q), 8'h3C);
      check("R7", "no collision when idle", int'(wcol), 0);

      run_seq(3, 0, 1'b0);
      run_seq(0, 0, 1'b1);
      wcol_clr = 1'b1;
      @(negedge clk);
      wcol_clr = 1'b0;
      check("R7", "collision flag cleared", int'(wcol), 0);
      run_seq(9, 6, 1'b1);
      repeat (5) @(negedge clk);
      check("R6", "all expected sequences seen", exp_q.size(), 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule